// File: doc/BRIEF.md
# Serial Memory Stream Transmitter

This block reads out a byte-wide memory bit by bit on an open-drain data line, with no commands, starting at reset. A slow external stream clock is sampled by the much faster system clock. Every rising stream-clock edge presents one new bit. The first nine edges after reset are a silent synchronisation period. After that, each byte goes out as a frame of nine bits: eight data bits, most significant first, then one released null bit. The read pointer walks through the whole address space and wraps to the start.

A second clock pin belongs to a bidirectional bus protocol that lives elsewhere in the device. While that pin stays high, streaming goes on. The first filtered falling edge on it sets a mode flag that only reset clears. At that moment the streamer releases the data line and stops reacting to the stream clock. Both clock pins go through a two-flop synchroniser and a stability filter before any edge counts.

Top module: `stream_tx_top`

## Requirements
- R1: During and right after reset, the data line is released (`sda_oe_o`=0), `bidir_mode_o` is 0 and `rd_addr_o` is 0.
- R2: For the first nine filtered rising stream-clock edges after reset, the data line stays released whatever the memory holds.
- R3: On the tenth rising edge, bit 7 of the byte at address 0 appears. Each later edge presents the next lower bit. A 0 bit drives the line low (`sda_oe_o`=1) and a 1 bit releases it.
- R4: The edge after bit 0 of a byte presents the null bit, which is always released. The edge after the null bit presents bit 7 of the byte at the next address.
- R5: The byte after the one at the last address (all ones) is the byte at address 0, with no gap in the stream.
- R6: A stream-clock pulse shorter than FILT_CYC system clocks is not counted as an edge. The bit sequence continues as if the pulse never happened.
- R7: While the bidirectional clock stays high, and also when it drops low for fewer than FILT_CYC system clocks, the mode flag stays 0 and streaming continues.
- R8: A filtered falling edge on the bidirectional clock sets `bidir_mode_o`. From the next cycle on, the data line is released, even in the middle of a driven-low bit.
- R9: Once set, `bidir_mode_o` stays 1 whatever the bidirectional clock does next. Later stream-clock edges leave the data line released.
- R10: A later reset returns the block to stream mode, and the synchronisation period starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Stream clock pin (asynchronous) |
| bclk_i | input | 1 | Bidirectional protocol clock pin (asynchronous) |
| rd_addr_o | output | ADDR_W | Memory read address, pointing at the next byte to load |
| rd_data_i | input | DATA_W | Memory read data for `rd_addr_o`, combinational |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| bidir_mode_o | output | 1 | Latched flag: bidirectional mode has been entered |

## Verification
The bench keeps the default ADDR_W of 7, so the full 128-byte space goes by in about 1,200 stream edges. The run covers the wrap from the last address back to 0, and it uses a memory pattern whose byte 0 begins with a 0 bit, so that the exact edge where output starts can be seen. FILT_CYC stays at 3, so one-cycle glitches on either clock fall under the filter while full stream-clock phases pass it with margin. SYNC_EDGES stays at 9 so that the silent period ends on the tenth edge.

// File: rtl/stream_tx_pkg.sv
package stream_tx_pkg;
  localparam int unsigned DEF_ADDR_W     = 7;
  localparam int unsigned DEF_DATA_W     = 8;
  localparam int unsigned DEF_FILT_CYC   = 3;
  localparam int unsigned DEF_SYNC_EDGES = 9;

  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_BIDIR  = 1'b1
  } mode_e;
endpackage

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
  parameter int unsigned FILT_CYC = 3,
  parameter bit          RST_LVL  = 1'b1,
  parameter bit          RISE     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);
  localparam int unsigned CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic [1:0]       sync_q;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_q;
  logic             hit;

  // polarity of the reported edge
  generate
    if (RISE) begin : g_rise
      assign hit = sync_q[1];
    end else begin : g_fall
      assign hit = ~sync_q[1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_LVL}};
      lvl_q  <= RST_LVL;
      cnt_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      edge_q <= 1'b0;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
        lvl_q  <= sync_q[1];
        cnt_q  <= '0;
        edge_q <= hit;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign edge_o = edge_q;

  generate
    if (FILT_CYC >= 2) begin : g_chk
      // R6
      glitch_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q != $past(lvl_q)) |-> ($past(sync_q[1]) == $past(sync_q[1], 2)));
    end
  endgenerate
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_EDGES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              halt_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o
);
  localparam int unsigned SC_W  = $clog2(SYNC_EDGES + 1);
  localparam int unsigned IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] NULL_IDX = IDX_W'(DATA_W);

  logic [SC_W-1:0]   sync_cnt_q;
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_cnt_q <= '0;
      active_q   <= 1'b0;
      idx_q      <= '0;
      shreg_q    <= '1;
      ptr_q      <= '0;
    end else if (adv_i) begin
      if (!active_q) begin
        if (sync_cnt_q == SC_W'(SYNC_EDGES)) begin
          active_q <= 1'b1;
          idx_q    <= '0;
          shreg_q  <= rd_data_i;
          ptr_q    <= ptr_q + 1'b1;
        end else begin
          sync_cnt_q <= sync_cnt_q + 1'b1;
        end
      end else if (idx_q == NULL_IDX) begin
        idx_q   <= '0;
        shreg_q <= rd_data_i;
        ptr_q   <= ptr_q + 1'b1;  // wraps at the top address
      end else begin
        idx_q   <= idx_q + 1'b1;
        shreg_q <= {shreg_q[DATA_W-2:0], 1'b1};
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = active_q && !halt_i && (idx_q != NULL_IDX) && !shreg_q[DATA_W-1];

  // R2
  sync_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sda_oe_o);
  // R4
  null_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == NULL_IDX) |-> !sda_oe_o);
  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/stream_tx_top.sv
module stream_tx_top
  import stream_tx_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned FILT_CYC   = DEF_FILT_CYC,
  parameter int unsigned SYNC_EDGES = DEF_SYNC_EDGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              bclk_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              bidir_mode_o
);
  logic  sclk_rise;
  logic  bclk_fall;
  mode_e mode_q;
  logic  bidir;

  pin_edge_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b0), .RISE(1'b1)) i_sclk_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(sclk_i), .edge_o(sclk_rise)
  );

  pin_edge_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b1), .RISE(1'b0)) i_bclk_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(bclk_i), .edge_o(bclk_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_STREAM;
    else if (bclk_fall) mode_q <= MODE_BIDIR;
  end

  assign bidir = (mode_q == MODE_BIDIR);

  frame_serializer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_EDGES(SYNC_EDGES)) i_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (sclk_rise && !bidir),
    .halt_i   (bidir),
    .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i),
    .sda_oe_o (sda_oe_o)
  );

  assign bidir_mode_o = bidir;

  // R8
  bidir_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidir_mode_o |-> !sda_oe_o);
  // R9
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidir_mode_o |=> bidir_mode_o);
  // R9
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bidir_mode_o) |-> $stable(rd_addr_o));
endmodule

// File: tb/test_stream_tx_top.sv
module test_stream_tx_top;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned HALF   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sclk = 1'b0;
  logic              bclk = 1'b1;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              sda_oe;
  logic              bidir;

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  bit done  = 0;

  bit    exp_q[$];
  string tag_q[$];
  event  smp;

  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_f(input int a);
    return DATA_W'((a * 37 + 5) & 8'hFF);
  endfunction

  assign rd_data = mem_f(int'(rd_addr));

  stream_tx_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(3), .SYNC_EDGES(9)) i_stream_tx_top (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .bclk_i(bclk),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .sda_oe_o(sda_oe), .bidir_mode_o(bidir)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected pull-low after the n-th edge since reset, stream mode
  function automatic bit model_oe(input int n);
    int k, b, bit_i;
    if (n < 10) return 1'b0;
    k = n - 10; b = (k / 9) % DEPTH; bit_i = k % 9;
    if (bit_i == 8) return 1'b0;
    return ~mem_f(b)[7 - bit_i];
  endfunction

  function automatic string model_tag(input int n);
    int k;
    if (n < 10) return "R2";
    k = n - 10;
    if (k % 9 == 8) return "R4";
    if (k / 9 >= DEPTH) return "R5";
    return "R3";
  endfunction

  task automatic push_edge(input bit exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    -> smp;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic stream_edge(input string force_tag);
    edges++;
    push_edge(model_oe(edges), (force_tag != "") ? force_tag : model_tag(edges));
  endtask

  task automatic sclk_glitch();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(smp);
      if (exp_q.size() == 0) begin
        chk("scoreboard", 32'd1, 32'd0);
      end else begin
        bit e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(sda_oe), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", 32'(sda_oe), 32'd0);
    chk("R1", 32'(bidir), 32'd0);
    chk("R1", 32'(rd_addr), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(sda_oe), 32'd0);

    // R2 silent period, with a short glitch inside (R6)
    for (int i = 0; i < 4; i++) stream_edge("");
    sclk_glitch();
    for (int i = 0; i < 5; i++) stream_edge("");
    // R3 tenth edge: MSB of byte 0 (0x05) is 0, line pulled low
    stream_edge("R3");
    // stream past the wrap (R3/R4/R5)
    for (int i = 0; i < 9 * (DEPTH + 2) - 1; i++) begin
      stream_edge("");
      if (i == 300) begin
        sclk_glitch();
        stream_edge("R6");
      end
    end

    // R7 short low glitch on bclk
    @(negedge clk) bclk = 1'b0;
    @(negedge clk) bclk = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7", 32'(bidir), 32'd0);
    stream_edge("R7");

    // R8 real falling edge
    @(negedge clk) bclk = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8", 32'(bidir), 32'd1);
    chk("R8", 32'(sda_oe), 32'd0);
    // R9 bclk high again, more stream edges
    @(negedge clk) bclk = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9", 32'(bidir), 32'd1);
    for (int i = 0; i < 6; i++) push_edge(1'b0, "R9");
    chk("R9", 32'(bidir), 32'd1);

    // R10 reset returns to stream mode
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", 32'(bidir), 32'd0);
    chk("R10", 32'(rd_addr), 32'd0);
    edges = 0;
    for (int i = 0; i < 9; i++) stream_edge("R10");
    stream_edge("R10");
    chk("R10", 32'(sda_oe), 32'd1);

    // R8 fall while the line is driven low
    @(negedge clk) bclk = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8", 32'(bidir), 32'd1);
    chk("R8", 32'(sda_oe), 32'd0);

    repeat (5) @(negedge clk);
    chk("queue", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule